// File: doc/BRIEF.md
# 64-bit Single-Step Execute Unit

This block holds the architectural state of a small 64-bit integer machine (thirty-one general registers, a program counter and four condition flags) and applies one already-decoded operation to that state per request. The caller presents an operation code, register indices, an immediate, a halfword select and an absolute address, raises `start_i` for one cycle while the unit is idle, and receives a one-cycle `done_o` pulse when the state update has been committed. Register-to-register operations finish in a single cycle. Loads and stores hold a request on a simple memory port until the memory acknowledges it.

The memory port reports faults. A faulting access commits nothing: registers, flags and the program counter all keep their values, and `fault_o` is raised together with `done_o`. A combinational read port (`peek_sel_i`/`peek_data_o`) exposes any register, so that the surrounding logic can observe the state without issuing an operation.

Top module: `exe_core`

## Requirements
- R1: After a synchronous active-low reset, `pc_o` equals RESET_PC (default 0), `flags_o` is 0, every register reads 0, and `busy_o` and `done_o` are low.
- R2: `op_i` codes are ADD 0, SUB 1, ADDS 2, SUBS 3, ADCS 4, SBCS 5, AND 6, ORR 7, EOR 8, LSL 9, LSR 10, MOV 11, MOVZ 12, MUL 13, RET 14, LDR 15, STR 16. A start accepted for codes 0 to 13 commits at that clock edge, pulses `done_o` in the following cycle, and sets the PC to its pre-operation value plus 4.
- R3: RET loads the PC with register 30 and does not add 4.
- R4: ADDS writes (Rn+Rm) mod 2^64, and ADCS writes (Rn+Rm+C) mod 2^64. C is set when the unbounded sum is at least 2^64.
- R5: SUBS writes (Rn-Rm) mod 2^64 with C = not(Rn < Rm). SBCS uses a borrow-in of 1 when C is clear, writes (Rn-Rm-borrow-in) mod 2^64, and sets C = not(Rn < Rm + borrow-in).
- R6: `flags_o` is {N,Z,C,V} from bit 3 down to bit 0. Flag-setting operations set Z when the result is zero and copy result bit 63 into N. V is never changed. ADD, SUB, AND, ORR, EOR, LSL, LSR, MOV, MOVZ and MUL leave all flags unchanged.
- R7: ADD and SUB wrap modulo 2^64. AND, ORR and EOR are bitwise. MOV copies Rn. MUL writes the low 64 bits of Rn*Rm.
- R8: LSL and LSR shift Rn by `imm_i`. A shift amount of 64 or more gives zero.
- R9: MOVZ writes `imm_i` shifted left by 16*`hw_i` and clears every other bit.
- R10: All source registers are read before the destination is written, so a destination that is also a source uses the old value.
- R11: Register index 31 reads as zero, and writes to it are discarded.
- R12: LDR and STR use address `addr_i` and register `rd_i`. While the access is pending, `busy_o` and `mem_req_o` stay high and address, write-enable and store data stay stable. A store drives the register's value on `mem_wdata_o`. On an acknowledge without fault, a load writes `mem_rdata_i` into the register, the PC advances by 4, and `done_o` pulses one cycle later.
- R13: When an access is acknowledged with `mem_fault_i` high, no register, flag or PC changes, and `fault_o` is high in the `done_o` cycle.
- R14: A start raised while busy is ignored. Codes 17 to 31 change no state but still pulse `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request to execute the presented operation |
| op_i | input | 5 | Operation code |
| rd_i | input | 5 | Destination index (data register for LDR/STR) |
| rn_i | input | 5 | First source index |
| rm_i | input | 5 | Second source index |
| imm_i | input | 16 | Shift amount or MOVZ immediate |
| hw_i | input | 2 | MOVZ halfword position |
| addr_i | input | 64 | LDR/STR address |
| busy_o | output | 1 | Memory access pending |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Completed operation faulted (valid with done_o) |
| pc_o | output | 64 | Program counter |
| flags_o | output | 4 | {N,Z,C,V} |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a store |
| mem_addr_o | output | 64 | Memory address |
| mem_wdata_o | output | 64 | Store data |
| mem_rdata_i | input | 64 | Load data |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_fault_i | input | 1 | Access faulted (valid with ack) |
| peek_sel_i | input | 5 | Register read-out select |
| peek_data_o | output | 64 | Register read-out value |

## Verification
A wrong flag update shows on `flags_o` in the cycle right after the committing edge, but a wrong register write stays hidden until the register is read through `peek_data_o` or used as an operand. For that reason the bench reads back every destination right after its operation. A PC slip (adding 4 on RET or on a faulted access) is visible on `pc_o` in the `done_o` cycle. A corrupted pending-access register shows on the memory port during the wait cycles, before the acknowledge arrives.

// File: rtl/exe_pkg.sv
// Shared types for the execute unit: operation codes and sequencer states.
// Assumes op codes are stable across decoder and execute unit.
package exe_pkg;
    localparam int HALF_W = 16;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,  OP_SUB  = 5'd1,  OP_ADDS = 5'd2,  OP_SUBS = 5'd3,
        OP_ADCS = 5'd4,  OP_SBCS = 5'd5,  OP_AND  = 5'd6,  OP_ORR  = 5'd7,
        OP_EOR  = 5'd8,  OP_LSL  = 5'd9,  OP_LSR  = 5'd10, OP_MOV  = 5'd11,
        OP_MOVZ = 5'd12, OP_MUL  = 5'd13, OP_RET  = 5'd14, OP_LDR  = 5'd15,
        OP_STR  = 5'd16
    } op_e;

    typedef enum logic {ST_IDLE = 1'b0, ST_MEM = 1'b1} st_e;
endpackage

// File: rtl/exe_regfile.sv
// Register file: NREG words, NRD combinational read ports, one write port.
// Assumes indices at or above NREG read as zero and ignore writes.
module exe_regfile #(
    parameter int XLEN = 64,
    parameter int NREG = 31,
    parameter int NRD  = 3,
    localparam int AW  = $clog2(NREG + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   rd_idx [NRD],
    output logic [XLEN-1:0] rd_data [NRD],
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_idx,
    input  logic [XLEN-1:0] wr_data
);
    logic [XLEN-1:0] regs [NREG];

    // Storage update: clear on reset, single write per cycle.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (!rst_n)
                regs[i] <= '0;
            else if (wr_en && (int'(wr_idx) == i))
                regs[i] <= wr_data;
        end
    end

    // One read mux per port; out-of-range index returns zero.
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            rd_data[p] = '0;
            for (int i = 0; i < NREG; i++)
                if (int'(rd_idx[p]) == i) rd_data[p] = regs[i];
        end
    end
endmodule

// File: rtl/exe_alu.sv
// Combinational datapath for register-to-register operations.
// Produces the result, the new N/Z/C values and whether flags are written.
// Assumes the caller only uses outputs for op codes OP_ADD..OP_MUL.
module exe_alu import exe_pkg::*; #(
    parameter int XLEN = 64
) (
    input  op_e              op,
    input  logic [XLEN-1:0]  a,
    input  logic [XLEN-1:0]  b,
    input  logic [HALF_W-1:0] imm,
    input  logic [1:0]       hw,
    input  logic             cin,
    output logic [XLEN-1:0]  res,
    output logic             flag_we,
    output logic             n_out,
    output logic             z_out,
    output logic             c_out
);
    logic [XLEN:0]   sum_w, dif_w;
    logic [XLEN-1:0] movz_w;
    logic            add_ci, sub_bi;

    // Carry/borrow inputs for the chained variants.
    always_comb begin
        add_ci = (op == OP_ADCS) ? cin : 1'b0;
        sub_bi = (op == OP_SBCS) ? ~cin : 1'b0;
    end

    // Wide adder and subtractor; top bit is carry or borrow.
    always_comb begin
        sum_w  = {1'b0, a} + {1'b0, b} + {{XLEN{1'b0}}, add_ci};
        dif_w  = {1'b0, a} - {1'b0, b} - {{XLEN{1'b0}}, sub_bi};
        movz_w = {{(XLEN-HALF_W){1'b0}}, imm} << (int'(hw) * HALF_W);
    end

    // Result select and flag computation.
    always_comb begin
        flag_we = 1'b0;
        c_out   = 1'b0;
        unique case (op)
            OP_ADD:  res = sum_w[XLEN-1:0];
            OP_SUB:  res = dif_w[XLEN-1:0];
            OP_ADDS, OP_ADCS: begin
                res = sum_w[XLEN-1:0]; flag_we = 1'b1; c_out = sum_w[XLEN];
            end
            OP_SUBS, OP_SBCS: begin
                res = dif_w[XLEN-1:0]; flag_we = 1'b1; c_out = ~dif_w[XLEN];
            end
            OP_AND:  res = a & b;
            OP_ORR:  res = a | b;
            OP_EOR:  res = a ^ b;
            OP_LSL:  res = a << imm;
            OP_LSR:  res = a >> imm;
            OP_MOV:  res = a;
            OP_MOVZ: res = movz_w;
            OP_MUL:  res = a * b;
            default: res = '0;
        endcase
        n_out = res[XLEN-1];
        z_out = (res == '0);
    end
endmodule

// File: rtl/exe_core.sv
// Execute unit top: architectural state (registers, PC, NZCV), start/done
// sequencing and a request/acknowledge memory port for 64-bit loads/stores.
// Assumes start_i is sampled only while idle; memory holds ack for one cycle.
module exe_core import exe_pkg::*; #(
    parameter int XLEN = 64,
    parameter int NREG = 31,
    parameter logic [XLEN-1:0] RESET_PC = '0,
    localparam int AW  = $clog2(NREG + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [4:0]       op_i,
    input  logic [AW-1:0]    rd_i,
    input  logic [AW-1:0]    rn_i,
    input  logic [AW-1:0]    rm_i,
    input  logic [HALF_W-1:0] imm_i,
    input  logic [1:0]       hw_i,
    input  logic [XLEN-1:0]  addr_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             fault_o,
    output logic [XLEN-1:0]  pc_o,
    output logic [3:0]       flags_o,
    output logic             mem_req_o,
    output logic             mem_we_o,
    output logic [XLEN-1:0]  mem_addr_o,
    output logic [XLEN-1:0]  mem_wdata_o,
    input  logic [XLEN-1:0]  mem_rdata_i,
    input  logic             mem_ack_i,
    input  logic             mem_fault_i,
    input  logic [AW-1:0]    peek_sel_i,
    output logic [XLEN-1:0]  peek_data_o
);
    localparam int LINK_IDX = NREG - 1;
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    op_e             op;
    st_e             st_q;
    logic [XLEN-1:0] pc_q, addr_q, wdata_q;
    logic [AW-1:0]   ld_rd_q;
    logic            we_q, done_q, fault_q;
    logic            n_q, z_q, c_q, v_q;
    logic            accept, is_compute, is_mem, ld_commit, mem_done;
    logic [AW-1:0]   rd_idx [3];
    logic [XLEN-1:0] rd_data [3];
    logic            wr_en;
    logic [AW-1:0]   wr_idx;
    logic [XLEN-1:0] wr_data, alu_res;
    logic            alu_fwe, alu_n, alu_z, alu_c;

    // Operation classification and handshake qualification.
    always_comb begin
        op         = op_e'(op_i);
        accept     = start_i && (st_q == ST_IDLE);
        is_compute = (op_i <= 5'(OP_MUL));
        is_mem     = (op == OP_LDR) || (op == OP_STR);
        mem_done   = (st_q == ST_MEM) && mem_ack_i;
        ld_commit  = mem_done && !mem_fault_i && !we_q;
    end

    // Read-port selection: RET reads the link register, STR reads its data register.
    always_comb begin
        rd_idx[0] = (op == OP_RET) ? AW'(LINK_IDX) : rn_i;
        rd_idx[1] = (op == OP_STR) ? rd_i : rm_i;
        rd_idx[2] = peek_sel_i;
    end

    // Single write port shared by compute results and load data.
    always_comb begin
        wr_en   = (accept && is_compute) || ld_commit;
        wr_idx  = ld_commit ? ld_rd_q : rd_i;
        wr_data = ld_commit ? mem_rdata_i : alu_res;
    end

    exe_regfile #(.XLEN(XLEN), .NREG(NREG), .NRD(3)) u_rf (
        .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_data(rd_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    exe_alu #(.XLEN(XLEN)) u_alu (
        .op(op), .a(rd_data[0]), .b(rd_data[1]), .imm(imm_i), .hw(hw_i),
        .cin(c_q), .res(alu_res), .flag_we(alu_fwe),
        .n_out(alu_n), .z_out(alu_z), .c_out(alu_c)
    );

    // Sequencer, PC, flags and pending-access registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            pc_q    <= RESET_PC;
            {n_q, z_q, c_q, v_q} <= 4'b0;
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            ld_rd_q <= '0;
            we_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                if (is_mem) begin
                    st_q    <= ST_MEM;
                    we_q    <= (op == OP_STR);
                    addr_q  <= addr_i;
                    wdata_q <= rd_data[1];
                    ld_rd_q <= rd_i;
                end else begin
                    done_q  <= 1'b1;
                    fault_q <= 1'b0;
                    if (is_compute) begin
                        pc_q <= pc_q + STEP;
                        if (alu_fwe) {n_q, z_q, c_q} <= {alu_n, alu_z, alu_c};
                    end else if (op == OP_RET) begin
                        pc_q <= rd_data[0];
                    end
                end
            end else if (mem_done) begin
                st_q    <= ST_IDLE;
                done_q  <= 1'b1;
                fault_q <= mem_fault_i;
                if (!mem_fault_i) pc_q <= pc_q + STEP;
            end
        end
    end

    // Port drive from state.
    always_comb begin
        busy_o      = (st_q == ST_MEM);
        done_o      = done_q;
        fault_o     = fault_q;
        pc_o        = pc_q;
        flags_o     = {n_q, z_q, c_q, v_q};
        mem_req_o   = (st_q == ST_MEM);
        mem_we_o    = we_q;
        mem_addr_o  = addr_q;
        mem_wdata_o = wdata_q;
        peek_data_o = rd_data[2];
    end
endmodule

// File: rtl/exe_core_chk.sv
// Protocol and state-update checker for exe_core, attached through bind.
// Assumes at least one cycle of reset before the first checked edge.
module exe_core_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic [4:0]      op_i,
    input logic            busy_o,
    input logic            done_o,
    input logic [XLEN-1:0] pc_o,
    input logic [3:0]      flags_o,
    input logic            mem_req_o,
    input logic [XLEN-1:0] mem_addr_o,
    input logic            mem_ack_i,
    input logic            mem_fault_i
);
    logic past_ok;

    // Marks that one post-reset sample exists for $stable comparisons.
    always_ff @(posedge clk) past_ok <= rst_n;

    AST_COMPUTE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && op_i <= 5'd13) |=> done_o);  // R2

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && op_i <= 5'd13) |=> (pc_o == $past(pc_o) + XLEN'(4)));  // R2

    AST_FLAGS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && (op_i <= 5'd1 || (op_i >= 5'd6 && op_i <= 5'd13)))
        |=> (flags_o == $past(flags_o)));  // R6

    AST_V_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        $stable(flags_o[0]));  // R6

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));  // R12

    AST_FAULT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_ack_i && mem_fault_i)
        |=> (pc_o == $past(pc_o) && flags_o == $past(flags_o)));  // R13

    AST_BUSY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o == mem_req_o);  // R12
endmodule

bind exe_core exe_core_chk #(.XLEN(XLEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .busy_o(busy_o), .done_o(done_o), .pc_o(pc_o), .flags_o(flags_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_ack_i(mem_ack_i), .mem_fault_i(mem_fault_i)
);

// File: tb/sim_exe_core.sv
// Directed bench for exe_core: one task per scenario, each checking itself.
module sim_exe_core;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    logic        clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
    logic [4:0]  op_i = '0, rd_i = '0, rn_i = '0, rm_i = '0, peek_sel_i = '0;
    logic [15:0] imm_i = '0;
    logic [1:0]  hw_i = '0;
    logic [63:0] addr_i = '0, mem_rdata_i = '0;
    logic        mem_ack_i = 1'b0, mem_fault_i = 1'b0;
    logic        busy_o, done_o, fault_o, mem_req_o, mem_we_o;
    logic [63:0] pc_o, mem_addr_o, mem_wdata_o, peek_data_o;
    logic [3:0]  flags_o;

    int total = 0, bad = 0;
    logic [63:0] exp_pc = '0;

    exe_core u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    task automatic peek(input logic [4:0] idx, output logic [63:0] val);
        peek_sel_i = idx;
        #1 val = peek_data_o;
    endtask

    task automatic run_op(input logic [4:0] op, input logic [4:0] rd, input logic [4:0] rn,
                          input logic [4:0] rm, input logic [15:0] imm, input logic [1:0] hw);
        @(negedge clk);
        op_i = op; rd_i = rd; rn_i = rn; rm_i = rm; imm_i = imm; hw_i = hw; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Compute op with destination and flags check; PC advances by 4.
    task automatic alu_case(input string req, input logic [4:0] op, input logic [4:0] rd,
                            input logic [4:0] rn, input logic [4:0] rm, input logic [15:0] imm,
                            input logic [1:0] hw, input logic [63:0] exp_v, input logic [3:0] exp_f);
        logic [63:0] v;
        run_op(op, rd, rn, rm, imm, hw);
        exp_pc += 64'd4;
        peek(rd, v);
        chk(req, "result", v, exp_v);
        chk(req, "flags", {60'd0, flags_o}, {60'd0, exp_f});
        chk("R2", "done", {63'd0, done_o}, 64'd1);
        chk("R2", "pc", pc_o, exp_pc);
    endtask

    // Memory access with a programmable wait and fault; returns after done cycle.
    task automatic mem_case(input logic [4:0] op, input logic [4:0] rd, input logic [63:0] addr,
                            input logic [63:0] rdata, input logic fault, input int waits);
        run_op(op, rd, 5'd0, 5'd0, 16'd0, 2'd0);
        addr_i = addr;
        for (int i = 0; i < waits; i++) @(negedge clk);
        mem_rdata_i = rdata; mem_fault_i = fault; mem_ack_i = 1'b1;
        @(negedge clk);
        mem_ack_i = 1'b0; mem_fault_i = 1'b0;
        chk("R12", "done after ack", {63'd0, done_o}, 64'd1);
        chk("R13", "fault flag", {63'd0, fault_o}, {63'd0, fault});
        if (!fault) exp_pc += 64'd4;
        chk("R13", "pc after access", pc_o, exp_pc);
    endtask

    task automatic t_reset();
        logic [63:0] v;
        peek(5'd7, v);
        chk("R1", "pc", pc_o, 64'd0);
        chk("R1", "flags", {60'd0, flags_o}, 64'd0);
        chk("R1", "reg", v, 64'd0);
        chk("R1", "busy/done", {62'd0, busy_o, done_o}, 64'd0);
    endtask

    task automatic t_load();
        logic [63:0] v;
        // Address must be set before start edge: set in advance.
        addr_i = 64'h80;
        mem_case(5'd15, 5'd1, 64'h80, ONES, 1'b0, 1);
        peek(5'd1, v); chk("R12", "load X1", v, ONES);
        mem_case(5'd15, 5'd2, 64'h88, 64'd1, 1'b0, 0);
        peek(5'd2, v); chk("R12", "load X2", v, 64'd1);
        mem_case(5'd15, 5'd30, 64'h90, 64'h1000, 1'b0, 2);
    endtask

    task automatic t_arith_flags();
        alu_case("R4", 5'd2, 5'd3, 5'd1, 5'd2, 0, 0, 64'd0, 4'b0110);        // ADDS carry out, zero
        alu_case("R4", 5'd4, 5'd4, 5'd2, 5'd2, 0, 0, 64'd3, 4'b0000);        // ADCS with C=1
        alu_case("R5", 5'd3, 5'd5, 5'd2, 5'd1, 0, 0, 64'd2, 4'b0000);        // SUBS borrow -> C=0
        alu_case("R5", 5'd5, 5'd7, 5'd2, 5'd31, 0, 0, 64'd0, 4'b0110);       // SBCS borrow-in 1, R11 zero reg
        alu_case("R5", 5'd3, 5'd6, 5'd1, 5'd2, 0, 0, ONES - 64'd1, 4'b1010); // SUBS negative, no borrow
        alu_case("R5", 5'd5, 5'd8, 5'd2, 5'd2, 0, 0, 64'd0, 4'b0110);        // SBCS borrow-in 0
    endtask

    task automatic t_plain_ops();
        alu_case("R7", 5'd0, 5'd9, 5'd1, 5'd2, 0, 0, 64'd0, 4'b0110);        // ADD wraps, flags held (R6)
        alu_case("R7", 5'd1, 5'd9, 5'd31, 5'd2, 0, 0, ONES, 4'b0110);        // SUB wraps
        alu_case("R7", 5'd13, 5'd10, 5'd1, 5'd1, 0, 0, 64'd1, 4'b0110);      // MUL low half
        alu_case("R7", 5'd6, 5'd11, 5'd1, 5'd2, 0, 0, 64'd1, 4'b0110);       // AND
        alu_case("R7", 5'd7, 5'd11, 5'd30, 5'd2, 0, 0, 64'h1001, 4'b0110);   // ORR
        alu_case("R7", 5'd8, 5'd12, 5'd1, 5'd2, 0, 0, ONES - 64'd1, 4'b0110);// EOR
        alu_case("R7", 5'd11, 5'd13, 5'd1, 5'd0, 0, 0, ONES, 4'b0110);       // MOV
    endtask

    task automatic t_shift_movz();
        alu_case("R8", 5'd9, 5'd14, 5'd2, 5'd0, 16'd63, 0, 64'h8000_0000_0000_0000, 4'b0110);
        alu_case("R8", 5'd10, 5'd15, 5'd14, 5'd0, 16'd63, 0, 64'd1, 4'b0110);
        alu_case("R8", 5'd9, 5'd16, 5'd1, 5'd0, 16'd64, 0, 64'd0, 4'b0110);
        alu_case("R8", 5'd10, 5'd17, 5'd1, 5'd0, 16'd200, 0, 64'd0, 4'b0110);
        alu_case("R9", 5'd12, 5'd18, 5'd0, 5'd0, 16'hABCD, 2'd3, 64'hABCD_0000_0000_0000, 4'b0110);
        alu_case("R9", 5'd12, 5'd18, 5'd0, 5'd0, 16'h1234, 2'd1, 64'h0000_0000_1234_0000, 4'b0110);
    endtask

    task automatic t_overlap_zero();
        logic [63:0] v;
        alu_case("R10", 5'd0, 5'd2, 5'd2, 5'd2, 0, 0, 64'd2, 4'b0110);       // X2 = X2 + X2
        run_op(5'd11, 5'd31, 5'd1, 5'd0, 0, 0);                              // MOV to index 31
        exp_pc += 64'd4;
        peek(5'd31, v); chk("R11", "index 31 after write", v, 64'd0);
        alu_case("R11", 5'd0, 5'd19, 5'd31, 5'd2, 0, 0, 64'd2, 4'b0110);
    endtask

    task automatic t_ret();
        run_op(5'd14, 5'd0, 5'd0, 5'd0, 0, 0);
        exp_pc = 64'h1000;
        chk("R3", "pc from link", pc_o, exp_pc);
        chk("R3", "done", {63'd0, done_o}, 64'd1);
    endtask

    task automatic t_store();
        addr_i = 64'h40;
        run_op(5'd16, 5'd18, 5'd0, 5'd0, 0, 0);
        for (int i = 0; i < 3; i++) begin
            chk("R12", "req held", {62'd0, mem_req_o, busy_o}, 64'd3);
            chk("R12", "store we", {63'd0, mem_we_o}, 64'd1);
            chk("R12", "store addr", mem_addr_o, 64'h40);
            chk("R12", "store data", mem_wdata_o, 64'h0000_0000_1234_0000);
            @(negedge clk);
        end
        mem_ack_i = 1'b1;
        @(negedge clk);
        mem_ack_i = 1'b0;
        exp_pc += 64'd4;
        chk("R12", "store done", {63'd0, done_o}, 64'd1);
        chk("R12", "store pc", pc_o, exp_pc);
        chk("R12", "req dropped", {63'd0, mem_req_o}, 64'd0);
    endtask

    task automatic t_faults();
        logic [63:0] v;
        logic [3:0]  f;
        f = flags_o;
        addr_i = 64'hDEAD;
        mem_case(5'd15, 5'd18, 64'hDEAD, 64'h5555, 1'b1, 1);
        peek(5'd18, v); chk("R13", "reg kept on load fault", v, 64'h0000_0000_1234_0000);
        chk("R13", "flags kept", {60'd0, flags_o}, {60'd0, f});
        mem_case(5'd16, 5'd18, 64'hDEAD, 64'd0, 1'b1, 0);
    endtask

    task automatic t_busy_undef();
        logic [63:0] v;
        addr_i = 64'h100;
        run_op(5'd15, 5'd20, 5'd0, 5'd0, 0, 0);
        op_i = 5'd12; rd_i = 5'd21; imm_i = 16'd5; hw_i = 2'd0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        mem_rdata_i = 64'd7; mem_ack_i = 1'b1;
        @(negedge clk);
        mem_ack_i = 1'b0;
        exp_pc += 64'd4;
        peek(5'd20, v); chk("R14", "load while start ignored", v, 64'd7);
        peek(5'd21, v); chk("R14", "ignored start wrote nothing", v, 64'd0);
        chk("R14", "pc single step", pc_o, exp_pc);
        run_op(5'd20, 5'd22, 5'd1, 5'd1, 0, 0);
        chk("R14", "undefined op done", {63'd0, done_o}, 64'd1);
        chk("R14", "undefined op pc", pc_o, exp_pc);
        peek(5'd22, v); chk("R14", "undefined op reg", v, 64'd0);
        chk("R6", "V never set", {63'd0, flags_o[0]}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_load();
        t_arith_flags();
        t_plain_ops();
        t_shift_movz();
        t_overlap_zero();
        t_ret();
        t_store();
        t_faults();
        t_busy_undef();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule